// File: doc/BRIEF.md
# Multiprocessor Serial Transceiver with Mute and Wake-up

This block is a full-duplex asynchronous serial transceiver for a shared multi-drop line. The host writes a word into a one-word transmit holding register. The transmitter serializes it with a start bit, the data bits least significant first, an optional parity bit and a stop bit. The receiver oversamples the input line, votes on each bit, and places completed words in a one-word receive register. Errors are reported through flags.

For buses with many listeners, the host can put the receiver to sleep (mute). A muted receiver delivers nothing and raises no receive interrupt. It wakes in one of two ways, chosen by `wake_sel`: when the line has stayed at mark for a whole frame, or when a word arrives with its most significant data bit set (an address word). The transmit and receive sides each have their own enable and their own baud divider input.

Top module: `mpuart`

## Requirements
- R1: After reset, `txd` is 1, `txe` and `tc` are 1, and `rxf`, `idle`, `ore`, `nf`, `fe`, `pe` and `muted` are 0.
- R2: A transmitted frame is a start bit at 0, then the data bits with bit 0 first, then a stop bit at 1. Each bit lasts 16×`tx_div` clocks, with a divider of 0 treated as 1.
- R3: When `word9`=1, words carry 9 data bits; otherwise they carry 8. The address mark is the top data bit: bit 8 for 9-bit words and bit 7 for 8-bit words.
- R4: When `par_en`=1, a parity bit follows the data bits. Its value is the XOR of the data bits, inverted when `par_odd`=1. On receive, a mismatch sets `pe`.
- R5: `wr_en` with `txe`=1 loads the holding register and clears `txe` and `tc`. `txe` returns to 1 when the word moves into the shifter. `tc` returns to 1 when a stop bit ends with the holding register empty. `wr_en` with `txe`=0 is ignored.
- R6: A word received while not muted sets `rxf` and appears on `rd_data`. `rd_en` clears `rxf`, `ore`, `nf`, `fe`, `pe` and `idle`.
- R7: If a word completes while `rxf` is still 1, `ore` is set and the new word is discarded, so `rd_data` keeps the old word.
- R8: If the stop bit is sampled at 0, `fe` is set and the word is still delivered.
- R9: Each bit is decided by a majority vote of oversamples 7, 8 and 9. If those samples disagree, `nf` is set for the word, and the voted data is still correct.
- R10: A `mute_req` pulse sets `muted`. While `muted` is set, received words do not set `rxf` and do not raise `irq_rx`.
- R11: With `wake_sel`=1, a muted receiver that gets a word with the address mark set clears `muted` and delivers that word. Words without the mark are dropped.
- R12: After at least one received word, one full frame time of continuous mark sets `idle` when not muted. When muted with `wake_sel`=0, it clears `muted` instead and does not set `idle`.
- R13: With `tx_en`=0, no new frame starts and `txd` stays at 1. With `rx_en`=0, nothing is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| tx_div | input | DIV_W | Clocks per transmit oversample tick |
| rx_div | input | DIV_W | Clocks per receive oversample tick |
| word9 | input | 1 | 1 selects 9-bit words |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | Odd parity when 1 |
| wake_sel | input | 1 | 0 wakes on idle line, 1 wakes on address word |
| mute_req | input | 1 | Pulse that puts the receiver in mute |
| wr_en | input | 1 | Write strobe for the transmit holding register |
| wr_data | input | 9 | Word to transmit |
| rd_en | input | 1 | Read strobe that clears the receive flags |
| rd_data | output | 9 | Last delivered received word |
| txe | output | 1 | Transmit holding register empty |
| tc | output | 1 | Transmission complete |
| rxf | output | 1 | Receive register full |
| idle | output | 1 | Idle line detected |
| ore | output | 1 | Overrun error |
| nf | output | 1 | Noise flag |
| fe | output | 1 | Framing error |
| pe | output | 1 | Parity error |
| muted | output | 1 | Receiver is muted |
| irq_tx | output | 1 | Transmit interrupt (holding register empty) |
| irq_rx | output | 1 | Receive interrupt (full, overrun or idle) |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |

## Verification
The assertions assume that the host raises `rd_en` and `wr_en` only as single-cycle strobes. They also assume the configuration inputs (`word9`, `par_en`, `par_odd`, the dividers) stay constant while a frame is in flight. The bench changes configuration only at negative edges while both lines are idle, and it pulses every strobe for exactly one clock. Incoming frames are built at the exact bit period for the receive divider. The only deliberate deviations are a glitch one oversample tick long, placed between the outer vote samples, and a stop bit forced low.

// File: rtl/mpuart_pkg.sv
package mpuart_pkg;
  localparam int OVS = 16;
  localparam int WMAX = 9;
  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} ser_st_e;
endpackage

// File: rtl/mpuart_baud.sv
module mpuart_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             last;

  assign last = (div <= DIV_W'(1)) || (cnt_q >= div - DIV_W'(1));
  assign tick = en & last;

  always_comb begin
    cnt_d = cnt_q + DIV_W'(1);
    if (!en || last) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
endmodule

// File: rtl/mpuart_tx.sv
module mpuart_tx
  import mpuart_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            tx_en,
  input  logic            word9,
  input  logic            par_en,
  input  logic            par_odd,
  input  logic            wr_en,
  input  logic [WMAX-1:0] wr_data,
  output logic            txd,
  output logic            txe,
  output logic            tc
);
  ser_st_e         st_q, st_d;
  logic [3:0]      sub_q, sub_d, bit_q, bit_d;
  logic [WMAX-1:0] shr_q, shr_d, hold_q, hold_d, hmask, tsh;
  logic            hfull_q, hfull_d, tc_q, tc_d, par_q, par_d;
  logic [3:0]      nlast;

  assign nlast = word9 ? 4'd8 : 4'd7;
  assign hmask = word9 ? hold_q : {1'b0, hold_q[7:0]};
  assign tsh   = shr_q >> bit_q;

  always_comb begin
    st_d = st_q; sub_d = sub_q; bit_d = bit_q; shr_d = shr_q;
    hold_d = hold_q; hfull_d = hfull_q; tc_d = tc_q; par_d = par_q;
    if (wr_en && !hfull_q) begin
      hold_d = wr_data; hfull_d = 1'b1; tc_d = 1'b0;
    end
    if (st_q == S_IDLE) begin
      if (hfull_q && tx_en) begin
        st_d = S_START; sub_d = '0; bit_d = '0;
        shr_d = hmask; par_d = (^hmask) ^ par_odd; hfull_d = 1'b0;
      end
    end else if (tick) begin
      sub_d = sub_q + 4'd1;
      if (sub_q == 4'd15) begin
        unique case (st_q)
          S_START: st_d = S_DATA;
          S_DATA:  if (bit_q == nlast) st_d = par_en ? S_PAR : S_STOP;
                   else bit_d = bit_q + 4'd1;
          S_PAR:   st_d = S_STOP;
          default: begin st_d = S_IDLE; tc_d = ~hfull_d; end
        endcase
      end
    end
  end

  always_comb begin
    unique case (st_q)
      S_START: txd = 1'b0;
      S_DATA:  txd = tsh[0];
      S_PAR:   txd = par_q;
      default: txd = 1'b1;
    endcase
  end

  assign txe = ~hfull_q;
  assign tc  = tc_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_q <= S_IDLE; sub_q <= '0; bit_q <= '0; shr_q <= '0; hold_q <= '0;
      hfull_q <= 1'b0; tc_q <= 1'b1; par_q <= 1'b0;
    end else begin
      st_q <= st_d; sub_q <= sub_d; bit_q <= bit_d; shr_q <= shr_d; hold_q <= hold_d;
      hfull_q <= hfull_d; tc_q <= tc_d; par_q <= par_d;
    end
endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx
  import mpuart_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            rx_en,
  input  logic            word9,
  input  logic            par_en,
  input  logic            par_odd,
  input  logic            rxd,
  output logic            done,
  output logic [WMAX-1:0] word,
  output logic            fe,
  output logic            pe,
  output logic            nf,
  output logic            idle_evt
);
  ser_st_e         st_q, st_d;
  logic [2:0]      sync_q;
  logic [3:0]      sub_q, sub_d, bit_q, bit_d, nlast, nfr;
  logic [1:0]      smp_q, smp_d;
  logic [WMAX-1:0] shr_q, shr_d, word_q, word_d;
  logic            nz_q, nz_d, pbad_q, pbad_d, seen_q, seen_d;
  logic            done_q, done_d, fe_q, fe_d, pe_q, pe_d, nf_q, nf_d, idl_q, idl_d;
  logic [7:0]      icnt_q, icnt_d, ftick;
  logic            rxs, fall, vote, disagree;

  assign rxs      = sync_q[1];
  assign fall     = sync_q[2] & ~sync_q[1];
  assign vote     = (smp_q[1] & smp_q[0]) | (smp_q[1] & rxs) | (smp_q[0] & rxs);
  assign disagree = !((smp_q[1] == smp_q[0]) && (smp_q[0] == rxs));
  assign nlast    = word9 ? 4'd8 : 4'd7;
  assign nfr      = nlast + 4'd3 + {3'b0, par_en};
  assign ftick    = {nfr, 4'b0};

  always_comb begin
    st_d = st_q; sub_d = sub_q; bit_d = bit_q; smp_d = smp_q; shr_d = shr_q;
    nz_d = nz_q; pbad_d = pbad_q; seen_d = seen_q; icnt_d = icnt_q;
    word_d = word_q; fe_d = fe_q; pe_d = pe_q; nf_d = nf_q;
    done_d = 1'b0; idl_d = 1'b0;
    if (!rx_en) begin
      st_d = S_IDLE; seen_d = 1'b0; icnt_d = '0;
    end else if (st_q == S_IDLE) begin
      if (fall) begin
        st_d = S_START; sub_d = '0; bit_d = '0; shr_d = '0;
        nz_d = 1'b0; pbad_d = 1'b0; icnt_d = '0;
      end else if (!rxs) icnt_d = '0;
      else if (tick && seen_q) begin
        if (icnt_q == ftick - 8'd1) begin
          idl_d = 1'b1; seen_d = 1'b0; icnt_d = '0;
        end else icnt_d = icnt_q + 8'd1;
      end
    end else if (tick) begin
      sub_d = sub_q + 4'd1;
      if (sub_q == 4'd7 || sub_q == 4'd8) smp_d = {smp_q[0], rxs};
      if (sub_q == 4'd9) begin
        nz_d = nz_q | disagree;
        unique case (st_q)
          S_START: if (vote) st_d = S_IDLE;
          S_DATA:  shr_d = shr_q | (WMAX'(vote) << bit_q);
          S_PAR:   pbad_d = vote ^ (^shr_q) ^ par_odd;
          default: begin
            done_d = 1'b1; word_d = shr_q; fe_d = ~vote; pe_d = pbad_q;
            nf_d = nz_q | disagree; st_d = S_IDLE; seen_d = 1'b1; icnt_d = '0;
          end
        endcase
      end
      if (sub_q == 4'd15) begin
        unique case (st_q)
          S_START: st_d = S_DATA;
          S_DATA:  if (bit_q == nlast) st_d = par_en ? S_PAR : S_STOP;
                   else bit_d = bit_q + 4'd1;
          S_PAR:   st_d = S_STOP;
          default: st_d = st_q;
        endcase
      end
    end
  end

  assign done = done_q; assign word = word_q; assign fe = fe_q;
  assign pe = pe_q; assign nf = nf_q; assign idle_evt = idl_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_q <= 3'b111; st_q <= S_IDLE; sub_q <= '0; bit_q <= '0; smp_q <= '0;
      shr_q <= '0; nz_q <= 1'b0; pbad_q <= 1'b0; seen_q <= 1'b0; icnt_q <= '0;
      word_q <= '0; fe_q <= 1'b0; pe_q <= 1'b0; nf_q <= 1'b0; done_q <= 1'b0; idl_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], rxd}; st_q <= st_d; sub_q <= sub_d; bit_q <= bit_d;
      smp_q <= smp_d; shr_q <= shr_d; nz_q <= nz_d; pbad_q <= pbad_d; seen_q <= seen_d;
      icnt_q <= icnt_d; word_q <= word_d; fe_q <= fe_d; pe_q <= pe_d; nf_q <= nf_d;
      done_q <= done_d; idl_q <= idl_d;
    end
endmodule

// File: rtl/mpuart.sv
module mpuart
  import mpuart_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic [DIV_W-1:0] tx_div,
  input  logic [DIV_W-1:0] rx_div,
  input  logic             word9,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic             wake_sel,
  input  logic             mute_req,
  input  logic             wr_en,
  input  logic [8:0]       wr_data,
  input  logic             rd_en,
  output logic [8:0]       rd_data,
  output logic             txe,
  output logic             tc,
  output logic             rxf,
  output logic             idle,
  output logic             ore,
  output logic             nf,
  output logic             fe,
  output logic             pe,
  output logic             muted,
  output logic             irq_tx,
  output logic             irq_rx,
  output logic             txd,
  input  logic             rxd
);
  localparam int NCH = 2;

  logic [DIV_W-1:0] div_a [NCH];
  logic [NCH-1:0]   en_a, tick_a;
  assign div_a[0] = tx_div; assign en_a[0] = 1'b1;
  assign div_a[1] = rx_div; assign en_a[1] = rx_en;

  for (genvar g = 0; g < NCH; g++) begin : g_baud
    mpuart_baud #(.DIV_W(DIV_W)) u_baud (
      .clk(clk), .rst_n(rst_n), .en(en_a[g]), .div(div_a[g]), .tick(tick_a[g]));
  end

  mpuart_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick_a[0]), .tx_en(tx_en), .word9(word9),
    .par_en(par_en), .par_odd(par_odd), .wr_en(wr_en), .wr_data(wr_data),
    .txd(txd), .txe(txe), .tc(tc));

  logic            rx_done, rx_fe, rx_pe, rx_nf, rx_idle;
  logic [WMAX-1:0] rx_word;

  mpuart_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick_a[1]), .rx_en(rx_en), .word9(word9),
    .par_en(par_en), .par_odd(par_odd), .rxd(rxd), .done(rx_done), .word(rx_word),
    .fe(rx_fe), .pe(rx_pe), .nf(rx_nf), .idle_evt(rx_idle));

  logic       rxf_q, rxf_d, ore_q, ore_d, nf_q, nf_d, fe_q, fe_d, pe_q, pe_d;
  logic       idle_q, idle_d, mute_q, mute_d, amark, wake;
  logic [8:0] dat_q, dat_d;

  assign amark = word9 ? rx_word[8] : rx_word[7];
  assign wake  = mute_q & wake_sel & amark;

  always_comb begin
    rxf_d = rxf_q; ore_d = ore_q; nf_d = nf_q; fe_d = fe_q; pe_d = pe_q;
    idle_d = idle_q; mute_d = mute_q; dat_d = dat_q;
    if (rd_en) begin
      rxf_d = 1'b0; ore_d = 1'b0; nf_d = 1'b0; fe_d = 1'b0; pe_d = 1'b0; idle_d = 1'b0;
    end
    if (mute_req) mute_d = 1'b1;
    if (rx_done && (!mute_q || wake)) begin
      mute_d = 1'b0;
      if (rxf_d) ore_d = 1'b1;
      else begin
        rxf_d = 1'b1; dat_d = rx_word; fe_d = rx_fe; pe_d = rx_pe; nf_d = rx_nf;
      end
    end
    if (rx_idle) begin
      if (!mute_q) idle_d = 1'b1;
      else if (!wake_sel) mute_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rxf_q <= 1'b0; ore_q <= 1'b0; nf_q <= 1'b0; fe_q <= 1'b0; pe_q <= 1'b0;
      idle_q <= 1'b0; mute_q <= 1'b0; dat_q <= '0;
    end else begin
      rxf_q <= rxf_d; ore_q <= ore_d; nf_q <= nf_d; fe_q <= fe_d; pe_q <= pe_d;
      idle_q <= idle_d; mute_q <= mute_d; dat_q <= dat_d;
    end

  assign rd_data = dat_q; assign rxf = rxf_q; assign ore = ore_q; assign nf = nf_q;
  assign fe = fe_q; assign pe = pe_q; assign idle = idle_q; assign muted = mute_q;
  assign irq_tx = txe;
  assign irq_rx = rxf_q | ore_q | idle_q;
endmodule

// File: rtl/mpuart_chk.sv
module mpuart_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic rd_en,
  input logic rx_done,
  input logic txd,
  input logic txe,
  input logic tc,
  input logic rxf,
  input logic ore,
  input logic muted
);
  a_r5_tc_line_mark: assert property (@(posedge clk) disable iff (!rst_n) tc |-> txd);
  a_r5_tc_implies_empty: assert property (@(posedge clk) disable iff (!rst_n) tc |-> txe);
  a_r7_ore_with_full: assert property (@(posedge clk) disable iff (!rst_n) $rose(ore) |-> rxf);
  a_r10_no_fill_muted: assert property (@(posedge clk) disable iff (!rst_n) $rose(rxf) |-> !muted);
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rx_done) |=> !rxf);
  a_r13_tx_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && tc) |=> txd);
endmodule

bind mpuart mpuart_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rd_en(rd_en), .rx_done(rx_done),
  .txd(txd), .txe(txe), .tc(tc), .rxf(rxf), .ore(ore), .muted(muted));

// File: tb/mpuart_tb.sv
module mpuart_tb;
  localparam int D  = 8;
  localparam int BT = 16 * D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b1, rx_en = 1'b1, word9 = 1'b0, par_en = 1'b0, par_odd = 1'b0;
  logic wake_sel = 1'b0, mute_req = 1'b0, wr_en = 1'b0, rd_en = 1'b0, rxd = 1'b1;
  logic [15:0] tx_div = 16'(D), rx_div = 16'(D);
  logic [8:0] wr_data = '0, rd_data;
  logic txe, tc, rxf, idle, ore, nf, fe, pe, muted, irq_tx, irq_rx, txd;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [8:0] exp_q[$];

  always #2.5 clk = ~clk;

  mpuart u_dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en), .tx_div(tx_div),
    .rx_div(rx_div), .word9(word9), .par_en(par_en), .par_odd(par_odd),
    .wake_sel(wake_sel), .mute_req(mute_req), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .txe(txe), .tc(tc), .rxf(rxf), .idle(idle),
    .ore(ore), .nf(nf), .fe(fe), .pe(pe), .muted(muted), .irq_tx(irq_tx),
    .irq_rx(irq_rx), .txd(txd), .rxd(rxd));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual cycle %0d expected under 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int nbits();
    return word9 ? 9 : 8;
  endfunction

  function automatic logic parity_of(input logic [8:0] w);
    logic [8:0] m = word9 ? w : {1'b0, w[7:0]};
    return (^m) ^ par_odd;
  endfunction

  // Behavioural line model: bit list of one frame for the current configuration
  task automatic build_frame(input logic [8:0] w, input logic pflip, input logic stopv,
                             output logic [15:0] fr, output int len);
    fr = '0; len = 0;
    fr[len++] = 1'b0;
    for (int i = 0; i < nbits(); i++) fr[len++] = w[i];
    if (par_en) fr[len++] = parity_of(w) ^ pflip;
    fr[len++] = stopv;
  endtask

  task automatic send_rx(input logic [8:0] w, input logic pflip, input logic stopv,
                         input int gbit);
    logic [15:0] fr; int len;
    build_frame(w, pflip, stopv, fr, len);
    for (int b = 0; b < len; b++)
      for (int c = 0; c < BT; c++) begin
        @(negedge clk);
        rxd = (b == gbit && c >= 8 * D + 4 && c < 9 * D + 4) ? ~fr[b] : fr[b];
      end
    @(negedge clk); rxd = 1'b1;
  endtask

  task automatic capture_tx(output logic [15:0] got, input int len);
    int t = 0;
    got = '0;
    while (txd !== 1'b0 && t < 20 * BT) begin @(negedge clk); t++; end
    t = 0;
    for (int k = 0; k < len; k++) begin
      while (t < k * BT + BT / 2) begin @(negedge clk); t++; end
      got[k] = txd;
    end
  endtask

  task automatic write_word(input logic [8:0] w);
    @(negedge clk); wr_en = 1'b1; wr_data = w;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic read_pulse();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic tx_frame_test(input logic [8:0] w, input string req);
    logic [15:0] fr, got; int len;
    build_frame(w, 1'b0, 1'b1, fr, len);
    write_word(w);
    capture_tx(got, len);
    chk(req, int'(got), int'(fr));
  endtask

  task automatic rx_deliver_test(input logic [8:0] w, input string req);
    exp_q.push_back(w);
    send_rx(w, 1'b0, 1'b1, -1);
    chk(req, int'(rxf), 1);
    chk(req, int'(rd_data), int'(exp_q.pop_front()));
  endtask

  initial begin
    ticks(4); rst_n = 1'b1; ticks(2);
    // R1 reset state
    chk("R1 txd", txd, 1); chk("R1 txe", txe, 1); chk("R1 tc", tc, 1);
    chk("R1 rx flags", {rxf, idle, ore, nf, fe, pe, muted}, 0);

    // R2 R5 8-bit transmit, flag sequence
    @(negedge clk); wr_en = 1'b1; wr_data = 9'h0A5;
    @(negedge clk); wr_en = 1'b0;
    chk("R5 txe cleared by write", txe, 0); chk("R5 tc cleared by write", tc, 0);
    @(negedge clk);
    chk("R5 txe after load", txe, 1);
    begin
      logic [15:0] fr, got; int len;
      build_frame(9'h0A5, 1'b0, 1'b1, fr, len);
      capture_tx(got, len);
      chk("R2 frame 0xA5", int'(got), int'(fr));
    end
    ticks(BT); chk("R5 tc after stop", tc, 1);

    // R5 write while holding full is ignored
    tx_en = 1'b0;
    write_word(9'h033); write_word(9'h0CC);
    tx_en = 1'b1;
    begin
      logic [15:0] fr, got; int len;
      build_frame(9'h033, 1'b0, 1'b1, fr, len);
      capture_tx(got, len);
      chk("R5 second write ignored", int'(got), int'(fr));
    end
    ticks(BT);

    // R3 R4 9-bit with even and odd parity
    word9 = 1'b1; par_en = 1'b1;
    tx_frame_test(9'h1C3, "R3 R4 9-bit even parity");
    ticks(BT);
    par_odd = 1'b1; word9 = 1'b0;
    tx_frame_test(9'h05A, "R4 8-bit odd parity");
    ticks(BT);
    par_en = 1'b0; par_odd = 1'b0;

    // R13 transmitter disabled holds the line
    tx_en = 1'b0;
    write_word(9'h0F0);
    begin
      int lows = 0;
      for (int i = 0; i < 3 * BT; i++) begin @(negedge clk); if (!txd) lows++; end
      chk("R13 no frame while tx disabled", lows, 0);
      chk("R13 word held", txe, 0);
    end
    tx_en = 1'b1;
    begin
      logic [15:0] fr, got; int len;
      build_frame(9'h0F0, 1'b0, 1'b1, fr, len);
      capture_tx(got, len);
      chk("R13 sends after enable", int'(got), int'(fr));
    end
    ticks(BT);

    // R6 receive and read-clear
    rx_deliver_test(9'h03C, "R6 receive 0x3C");
    chk("R6 irq_rx", irq_rx, 1);
    chk("R6 no errors", {ore, fe, pe, nf}, 0);
    read_pulse(); chk("R6 rxf cleared by read", rxf, 0);

    // R7 overrun
    rx_deliver_test(9'h011, "R7 first word");
    send_rx(9'h022, 1'b0, 1'b1, -1);
    chk("R7 ore", ore, 1); chk("R7 old word kept", rd_data, 9'h011);
    read_pulse(); chk("R6 ore cleared by read", ore, 0);

    // R12 idle detection while not muted
    ticks(12 * BT);
    chk("R12 idle flag", idle, 1); chk("R12 irq_rx on idle", irq_rx, 1);
    read_pulse();

    // R8 framing error, word still delivered
    exp_q.push_back(9'h055);
    send_rx(9'h055, 1'b0, 1'b0, -1);
    chk("R8 fe", fe, 1); chk("R8 word delivered", rd_data, int'(exp_q.pop_front()));
    ticks(BT); read_pulse();

    // R4 parity error on receive (9-bit, odd)
    word9 = 1'b1; par_en = 1'b1; par_odd = 1'b1;
    rx_deliver_test(9'h1A7, "R4 good parity word");
    chk("R4 no pe", pe, 0); read_pulse();
    send_rx(9'h0B4, 1'b1, 1'b1, -1);
    chk("R4 pe", pe, 1); chk("R3 9-bit data", rd_data, 9'h0B4);
    read_pulse();
    word9 = 1'b0; par_en = 1'b0; par_odd = 1'b0;

    // R9 noise: glitch on data bit 3 (frame index 4)
    send_rx(9'h0C9, 1'b0, 1'b1, 4);
    chk("R9 nf", nf, 1); chk("R9 voted data", rd_data, 9'h0C9);
    read_pulse();
    send_rx(9'h0C9, 1'b0, 1'b1, -1);
    chk("R9 clean word no nf", nf, 0);
    read_pulse();
    ticks(12 * BT); read_pulse();

    // R10 R11 mute, address wake
    wake_sel = 1'b1;
    @(negedge clk); mute_req = 1'b1; @(negedge clk); mute_req = 1'b0;
    chk("R10 muted", muted, 1);
    send_rx(9'h012, 1'b0, 1'b1, -1);
    chk("R10 no rxf while muted", rxf, 0); chk("R10 no irq while muted", irq_rx, 0);
    chk("R11 still muted", muted, 1);
    send_rx(9'h085, 1'b0, 1'b1, -1);
    chk("R11 woken", muted, 0); chk("R11 address delivered", rxf, 1);
    chk("R11 address data", rd_data, 9'h085);
    read_pulse();
    ticks(12 * BT); read_pulse();

    // R12 idle-line wake
    wake_sel = 1'b0;
    @(negedge clk); mute_req = 1'b1; @(negedge clk); mute_req = 1'b0;
    send_rx(9'h0FF, 1'b0, 1'b1, -1);
    chk("R10 muted drop with address", rxf, 0);
    chk("R12 muted before idle", muted, 1);
    ticks(12 * BT);
    chk("R12 idle wake", muted, 0); chk("R12 no idle flag when waking", idle, 0);

    // R13 receiver disabled
    rx_en = 1'b0;
    send_rx(9'h066, 1'b0, 1'b1, -1);
    chk("R13 nothing received", rxf, 0);
    rx_en = 1'b1; ticks(4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule